// File: doc/BRIEF.md
# Grouped Beep-Pattern Sequencer

This block plays diagnostic beep patterns on a speaker. It drives a speaker-enable output and a tone-select bit. It latches a pattern on a start pulse, plays it once, and holds a busy flag for as long as it is playing. Tone synthesis is left to a downstream oscillator that reads the select bit.

A mode input chooses one of three encodings. In count mode, up to four 3-bit group counts give the number of equal short beeps in each group. A short gap separates the beeps of one group, and a longer pause separates the groups, so the pattern 1-2-2-3 plays one beep, then two, then two, then three. In long/short mode, an 8-bit mask and a length field give a run of beeps, each either long or short. Tone mode uses the same mask to pick a low or a high tone for each short beep. A separate pass command plays one short beep to report that every test completed.

All durations are parameters, set in units of a base tick count. By default the units are: short beep 1, long beep 3, gap 1, pause 4.

Top module: `beep_sequencer`

## Requirements
- R1: In count mode (`modeSel` = 00), groups are played in order: group 0 from `groupCounts[2:0]`, then `[5:3]`, `[8:6]` and `[11:9]`. Each group plays its count of beeps, each beep SHORT ticks long with tone low. The speaker is off for GAP ticks between the beeps of a group and for PAUSE ticks between groups.
- R2: In count mode a group count of 0 ends the pattern at that group, and at most four groups play. A start whose group 0 count is 0 plays nothing, and busy stays low.
- R3: In long/short mode (`modeSel` = 01), `maskLen`+1 beeps (1 to 8) play, separated by GAP ticks. Beep k uses `beepMask[7-k]` (most significant bit first): 1 gives a LONG-tick beep and 0 gives a SHORT-tick beep. Tone is low.
- R4: In tone mode (`modeSel` = 10), the beep count, order and gaps are those of R3, but every beep is SHORT ticks long. During beep k, `toneHigh` equals `beepMask[7-k]`.
- R5: `toneHigh` is never high while `speakerOn` is low.
- R6: `modeSel` = 11 behaves exactly as count mode.
- R7: A `passPulse` seen while idle plays a single SHORT-tick beep with tone low, whatever the pattern inputs hold. It takes priority over a `startPulse` in the same cycle.
- R8: `speakerOn` and `busy` rise in the first cycle after the clock edge that samples the command. `busy` falls in the same cycle that `speakerOn` falls at the end of the final beep.
- R9: `startPulse` and `passPulse` seen while busy are ignored. Changes to the pattern inputs while busy do not affect the pattern being played.
- R10: While the asynchronous active-low reset `rstN` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Starts the pattern on the pattern inputs |
| passPulse | input | 1 | Plays one short success beep |
| modeSel | input | 2 | 00/11 count, 01 long/short, 10 tone |
| groupCounts | input | 12 | Four 3-bit group counts, group 0 in the low bits |
| beepMask | input | 8 | Per-beep long or high select, MSB first |
| maskLen | input | 3 | Number of mask beeps minus one |
| speakerOn | output | 1 | Speaker enable |
| toneHigh | output | 1 | High-tone select |
| busy | output | 1 | A pattern is playing |

## Verification
A command sampled at one clock edge shows on `speakerOn` and `busy` one cycle later. Every later segment follows back to back, with a length equal to its parameterised tick count. The bench therefore builds the expected per-cycle trace of speaker, tone and busy from the requirements. It starts comparing in the first cycle after the sampling edge and goes on for three idle cycles past the predicted end of the pattern. Inputs change and outputs are read at the falling edge, so every comparison falls midway between the register updates it depends on.

// File: rtl/beep_seq_pkg.sv
package beep_seq_pkg;

  typedef enum logic [1:0] {
    MODE_COUNT     = 2'b00,
    MODE_LONGSHORT = 2'b01,
    MODE_TONE      = 2'b10,
    MODE_COUNT_ALT = 2'b11
  } beepMode_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;        // latch a new pattern and time its first beep
    logic pass;        // with load: single short success beep
    logic gapStart;    // beep ended, another beep follows in this group
    logic pauseStart;  // beep ended, next group follows
    logic beepNext;    // gap or pause ended, time the next beep
  } seqStrobe_t;

  // status from the datapath to the control
  typedef struct packed {
    logic timerDone;
    logic lastBeep;
    logic moreGroups;
    logic patternEmpty;
    logic curHigh;
  } seqStatus_t;

endpackage

// File: rtl/beep_seq_datapath.sv
module beep_seq_datapath
  import beep_seq_pkg::*;
#(
  parameter int UNIT_TICKS  = 2,
  parameter int SHORT_UNITS = 1,
  parameter int LONG_UNITS  = 3,
  parameter int GAP_UNITS   = 1,
  parameter int PAUSE_UNITS = 4,
  parameter int GROUPS      = 4,
  parameter int COUNT_W     = 3,
  parameter int MASK_W      = 8,
  parameter int LEN_W       = $clog2(MASK_W)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 strb,
  input  logic [1:0]                 modeIn,
  input  logic [GROUPS*COUNT_W-1:0]  countsIn,
  input  logic [MASK_W-1:0]          maskIn,
  input  logic [LEN_W-1:0]           lenIn,
  output seqStatus_t                 status
);

  localparam int SHORT_T = UNIT_TICKS * SHORT_UNITS;
  localparam int LONG_T  = UNIT_TICKS * LONG_UNITS;
  localparam int GAP_T   = UNIT_TICKS * GAP_UNITS;
  localparam int PAUSE_T = UNIT_TICKS * PAUSE_UNITS;
  localparam int MAX_A   = (SHORT_T > LONG_T) ? SHORT_T : LONG_T;
  localparam int MAX_B   = (GAP_T > PAUSE_T) ? GAP_T : PAUSE_T;
  localparam int MAX_T   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TIMER_W = $clog2(MAX_T + 1);
  localparam int GIDX_W  = $clog2(GROUPS);
  localparam int BEEP_W  = (COUNT_W > LEN_W + 1) ? COUNT_W : LEN_W + 1;

  beepMode_e            modeReg;
  logic [GROUPS*COUNT_W-1:0] countsReg;
  logic [MASK_W-1:0]    maskReg;
  logic [BEEP_W-1:0]    beepsLeft;
  logic [GIDX_W-1:0]    groupIdx;
  logic [GIDX_W-1:0]    nextIdx;
  logic [TIMER_W-1:0]   timer;
  logic [COUNT_W-1:0]   groupOf [GROUPS];
  logic [COUNT_W-1:0]   nextCount;
  logic                 lastGroup;
  beepMode_e            modeNew;

  for (genvar g = 0; g < GROUPS; g++) begin : g_split
    assign groupOf[g] = countsReg[g*COUNT_W +: COUNT_W];
  end

  function automatic logic isCountMode(beepMode_e m);
    return (m == MODE_COUNT) || (m == MODE_COUNT_ALT);
  endfunction

  function automatic logic [TIMER_W-1:0] beepTicks(beepMode_e m, logic longBit);
    if (m == MODE_LONGSHORT && longBit) return TIMER_W'(LONG_T - 1);
    return TIMER_W'(SHORT_T - 1);
  endfunction

  assign modeNew   = beepMode_e'(modeIn);
  assign nextIdx   = groupIdx + GIDX_W'(1);
  assign lastGroup = (groupIdx == GIDX_W'(GROUPS - 1));
  assign nextCount = lastGroup ? '0 : groupOf[nextIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg   <= MODE_COUNT;
      countsReg <= '0;
      maskReg   <= '0;
      beepsLeft <= '0;
      groupIdx  <= '0;
      timer     <= '0;
    end else if (strb.load && strb.pass) begin
      modeReg   <= MODE_COUNT;
      countsReg <= '0;
      maskReg   <= '0;
      beepsLeft <= BEEP_W'(1);
      groupIdx  <= '0;
      timer     <= TIMER_W'(SHORT_T - 1);
    end else if (strb.load) begin
      modeReg   <= modeNew;
      countsReg <= countsIn;
      maskReg   <= maskIn;
      groupIdx  <= '0;
      beepsLeft <= isCountMode(modeNew) ? BEEP_W'(countsIn[COUNT_W-1:0])
                                        : BEEP_W'(lenIn) + BEEP_W'(1);
      timer     <= beepTicks(modeNew, maskIn[MASK_W-1]);
    end else if (strb.gapStart) begin
      timer     <= TIMER_W'(GAP_T - 1);
      beepsLeft <= beepsLeft - BEEP_W'(1);
      maskReg   <= maskReg << 1;
    end else if (strb.pauseStart) begin
      timer     <= TIMER_W'(PAUSE_T - 1);
      groupIdx  <= nextIdx;
      beepsLeft <= BEEP_W'(nextCount);
      maskReg   <= maskReg << 1;
    end else if (strb.beepNext) begin
      timer     <= beepTicks(modeReg, maskReg[MASK_W-1]);
    end else if (timer != '0) begin
      timer     <= timer - TIMER_W'(1);
    end
  end

  assign status.timerDone    = (timer == '0);
  assign status.lastBeep     = (beepsLeft == BEEP_W'(1));
  assign status.moreGroups   = isCountMode(modeReg) && !lastGroup && (nextCount != '0);
  assign status.patternEmpty = isCountMode(modeNew) && (countsIn[COUNT_W-1:0] == '0);
  assign status.curHigh      = (modeReg == MODE_TONE) && maskReg[MASK_W-1];

  // R8
  timer_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timer != '0 && !(strb.load || strb.gapStart || strb.pauseStart || strb.beepNext))
    |=> timer == $past(timer) - TIMER_W'(1));

  // R2
  gap_needs_beep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.gapStart |-> beepsLeft > BEEP_W'(1));

endmodule

// File: rtl/beep_seq_ctrl.sv
module beep_seq_ctrl
  import beep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       passCmd,
  input  seqStatus_t status,
  output seqStrobe_t strb,
  output logic       speakerOn,
  output logic       toneHigh,
  output logic       busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_BEEP, ST_GAP, ST_PAUSE} seqState_e;

  seqState_e state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (passCmd) begin
          strb.load = 1'b1;
          strb.pass = 1'b1;
          stateNext = ST_BEEP;
        end else if (start && !status.patternEmpty) begin
          strb.load = 1'b1;
          stateNext = ST_BEEP;
        end
      end
      ST_BEEP: begin
        if (status.timerDone) begin
          if (!status.lastBeep) begin
            strb.gapStart = 1'b1;
            stateNext     = ST_GAP;
          end else if (status.moreGroups) begin
            strb.pauseStart = 1'b1;
            stateNext       = ST_PAUSE;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_GAP, ST_PAUSE: begin
        if (status.timerDone) begin
          strb.beepNext = 1'b1;
          stateNext     = ST_BEEP;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign speakerOn = (state == ST_BEEP);
  assign busy      = (state != ST_IDLE);
  assign toneHigh  = speakerOn && status.curHigh;

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start || passCmd));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (start || passCmd)) |-> !strb.load);

endmodule

// File: rtl/beep_sequencer.sv
module beep_sequencer
  import beep_seq_pkg::*;
#(
  parameter int UNIT_TICKS  = 2,
  parameter int SHORT_UNITS = 1,
  parameter int LONG_UNITS  = 3,
  parameter int GAP_UNITS   = 1,
  parameter int PAUSE_UNITS = 4,
  parameter int GROUPS      = 4,
  parameter int COUNT_W     = 3,
  parameter int MASK_W      = 8,
  localparam int LEN_W      = $clog2(MASK_W)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startPulse,
  input  logic                      passPulse,
  input  logic [1:0]                modeSel,
  input  logic [GROUPS*COUNT_W-1:0] groupCounts,
  input  logic [MASK_W-1:0]         beepMask,
  input  logic [LEN_W-1:0]          maskLen,
  output logic                      speakerOn,
  output logic                      toneHigh,
  output logic                      busy
);

  seqStrobe_t strb;
  seqStatus_t status;

  beep_seq_datapath #(
    .UNIT_TICKS (UNIT_TICKS),
    .SHORT_UNITS(SHORT_UNITS),
    .LONG_UNITS (LONG_UNITS),
    .GAP_UNITS  (GAP_UNITS),
    .PAUSE_UNITS(PAUSE_UNITS),
    .GROUPS     (GROUPS),
    .COUNT_W    (COUNT_W),
    .MASK_W     (MASK_W),
    .LEN_W      (LEN_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .modeIn  (modeSel),
    .countsIn(groupCounts),
    .maskIn  (beepMask),
    .lenIn   (maskLen),
    .status  (status)
  );

  beep_seq_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (startPulse),
    .passCmd  (passPulse),
    .status   (status),
    .strb     (strb),
    .speakerOn(speakerOn),
    .toneHigh (toneHigh),
    .busy     (busy)
  );

  // R5
  tone_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    toneHigh |-> speakerOn);

endmodule

// File: tb/test_beep_sequencer.sv
`timescale 1ns/1ps
module test_beep_sequencer;

  localparam int UT = 2, SU = 1, LU = 3, GU = 1, PU = 4;
  localparam int SHORT = UT*SU, LONG = UT*LU, GAP = UT*GU, PAUSE = UT*PU;
  localparam int NV = 11;
  // {pass, mode, counts (g3 g2 g1 g0 in octal), mask, len}
  localparam logic [25:0] VECS [NV] = '{
    {1'b0, 2'd0, 12'o3221, 8'h00, 3'd0},
    {1'b0, 2'd0, 12'o0003, 8'h00, 3'd0},
    {1'b0, 2'd0, 12'o0502, 8'h00, 3'd0},
    {1'b0, 2'd0, 12'o7777, 8'h00, 3'd0},
    {1'b0, 2'd1, 12'o0000, 8'hA0, 3'd2},
    {1'b0, 2'd1, 12'o0000, 8'hFF, 3'd7},
    {1'b0, 2'd2, 12'o0000, 8'h60, 3'd3},
    {1'b0, 2'd2, 12'o0000, 8'h80, 3'd0},
    {1'b0, 2'd3, 12'o0012, 8'h00, 3'd0},
    {1'b1, 2'd1, 12'o3221, 8'hFF, 3'd7},
    {1'b0, 2'd0, 12'o0030, 8'h00, 3'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0, passPulse = 1'b0;
  logic [1:0] modeSel = '0;
  logic [11:0] groupCounts = '0;
  logic [7:0] beepMask = '0;
  logic [2:0] maskLen = '0;
  logic speakerOn, toneHigh, busy;

  int checks = 0, errors = 0;
  logic expSpk [512];
  logic expTone [512];
  int expLen;

  always #2 clk = ~clk;

  beep_sequencer #(.UNIT_TICKS(UT), .SHORT_UNITS(SU), .LONG_UNITS(LU),
                   .GAP_UNITS(GU), .PAUSE_UNITS(PU)) i_beep_sequencer (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .passPulse(passPulse),
    .modeSel(modeSel), .groupCounts(groupCounts), .beepMask(beepMask),
    .maskLen(maskLen), .speakerOn(speakerOn), .toneHigh(toneHigh), .busy(busy));

  task automatic check(input string tag, input logic ok, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic addSeg(input logic on, input logic hi, input int dur);
    for (int t = 0; t < dur; t++) begin
      expSpk[expLen]  = on;
      expTone[expLen] = hi;
      expLen++;
    end
  endtask

  task automatic buildExp(input logic pass, input logic [1:0] m,
                          input logic [11:0] c, input logic [7:0] mk,
                          input logic [2:0] ln);
    expLen = 0;
    for (int i = 0; i < 512; i++) begin
      expSpk[i] = 1'b0;
      expTone[i] = 1'b0;
    end
    if (pass) addSeg(1'b1, 1'b0, SHORT);
    else if (m == 2'd1 || m == 2'd2) begin
      for (int k = 0; k <= int'(ln); k++) begin
        if (k > 0) addSeg(1'b0, 1'b0, GAP);
        if (m == 2'd1) addSeg(1'b1, 1'b0, mk[7-k] ? LONG : SHORT);
        else           addSeg(1'b1, mk[7-k], SHORT);
      end
    end else begin
      for (int g = 0; g < 4; g++) begin
        int cnt;
        cnt = int'(c[g*3 +: 3]);
        if (cnt == 0) break;
        if (g > 0) addSeg(1'b0, 1'b0, PAUSE);
        for (int b = 0; b < cnt; b++) begin
          if (b > 0) addSeg(1'b0, 1'b0, GAP);
          addSeg(1'b1, 1'b0, SHORT);
        end
      end
    end
  endtask

  // plays one pattern; injectAt >= 0 pulses commands and scrambles inputs mid-run
  task automatic runSeq(input logic [25:0] v, input string tag, input int injectAt);
    int spkBadAt, busyBadAt;
    logic gotSpk, gotTone, gotBusy;
    buildExp(v[25], v[24:23], v[22:11], v[10:3], v[2:0]);
    spkBadAt = -1; busyBadAt = -1;
    gotSpk = 0; gotTone = 0; gotBusy = 0;
    @(negedge clk);
    passPulse = v[25]; modeSel = v[24:23]; groupCounts = v[22:11];
    beepMask = v[10:3]; maskLen = v[2:0]; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0; passPulse = 1'b0;
    for (int i = 0; i < expLen + 3; i++) begin
      if (i == injectAt) begin
        startPulse = 1'b1; passPulse = 1'b1;
        modeSel = ~modeSel; groupCounts = ~groupCounts;
        beepMask = ~beepMask; maskLen = ~maskLen;
      end else if (i == injectAt + 1) begin
        startPulse = 1'b0; passPulse = 1'b0;
      end
      if (spkBadAt < 0 && (speakerOn !== (i < expLen ? expSpk[i] : 1'b0) ||
                           toneHigh  !== (i < expLen ? expTone[i] : 1'b0))) begin
        spkBadAt = i; gotSpk = speakerOn; gotTone = toneHigh;
      end
      if (busyBadAt < 0 && busy !== (i < expLen)) begin
        busyBadAt = i; gotBusy = busy;
      end
      @(negedge clk);
    end
    check(tag, spkBadAt < 0, "speaker/tone trace (first bad cycle, value spk*2+tone)",
          spkBadAt < 0 ? 0 : int'({gotSpk, gotTone}),
          spkBadAt < 0 ? 0 : int'({expSpk[spkBadAt], expTone[spkBadAt]}));
    check({tag, " R8"}, busyBadAt < 0, $sformatf("busy at cycle %0d", busyBadAt),
          int'(gotBusy), busyBadAt < 0 ? 0 : int'(busyBadAt < expLen));
  endtask

  function automatic string tagOf(input logic [25:0] v);
    if (v[25]) return "R7";
    case (v[24:23])
      2'd1: return "R3";
      2'd2: return "R4 R5";
      2'd3: return "R6";
      default: begin
        if (v[13:11] == 0 || v[16:14] == 0 || v[19:17] == 0 || v[22:20] == 0)
          return "R2";
        return "R1";
      end
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 outputs low during reset
    check("R10", {speakerOn, toneHigh, busy} === 3'b000, "outputs in reset",
          int'({speakerOn, toneHigh, busy}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", {speakerOn, toneHigh, busy} === 3'b000, "outputs after reset",
          int'({speakerOn, toneHigh, busy}), 0);

    for (int n = 0; n < NV; n++) runSeq(VECS[n], tagOf(VECS[n]), -1);

    // R9 start/pass while busy and input changes during play have no effect
    runSeq(VECS[0], "R9 count", 5);
    runSeq(VECS[4], "R9 longshort", 3);
    runSeq(VECS[6], "R9 tone", 1);

    // R10 reset in mid-pattern forces outputs low at once
    @(negedge clk);
    modeSel = 2'd2; beepMask = 8'hFF; maskLen = 3'd7; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    @(negedge clk);
    check("R4", {speakerOn, toneHigh} === 2'b11, "tone beep before reset",
          int'({speakerOn, toneHigh}), 3);
    rstN = 1'b0;
    #1;
    check("R10", {speakerOn, toneHigh, busy} === 3'b000, "outputs on mid-run reset",
          int'({speakerOn, toneHigh, busy}), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", busy === 1'b0, "busy after mid-run reset", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule